// File: doc/BRIEF.md
# Three-Phase Gate Output Steering and Shutdown Latch

This block takes the six raw pulse-width signals of a three-phase timer (a high-side and a low-side signal for each of channels A, B and C) and turns them into the six gate-drive outputs. For each channel, a configuration bit can swap the channel's two signals between its high-side and low-side outputs. Each output can also be masked on its own, and a high-frequency chopping carrier can be ANDed into the high-side outputs, the low-side outputs, or both.

The block also watches three shutdown sources: an active-low external trip pin, an over-current flag and a software shutdown bit. When any of them becomes active, all six outputs are forced low, and a latched shutdown state is entered. That state holds the timer in reset and raises a one-cycle interrupt request. The state persists until software asks for it to be cleared at a moment when no source is active.

All configuration and control inputs are plain level signals sampled every clock. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `pwm_out_ctrl`

## Requirements
- R1: With crossover bit `seg_cfg[c]` low (c = 0, 1, 2 for channels A, B, C), output bit 2c follows raw bit 2c and output bit 2c+1 follows raw bit 2c+1. Bit order in `pwm_raw` and `pwm_out` is AH, AL, BH, BL, CH, CL from bit 0 up. The outputs are combinational from the raw inputs.
- R2: With `seg_cfg[c]` high, the channel's two signals are swapped: output bit 2c follows raw bit 2c+1, and output bit 2c+1 follows raw bit 2c.
- R3: `seg_cfg[3+i]` high forces output bit i low, for i = 0 to 5. The mask is applied after the crossover.
- R4: The chopping carrier is high for D+1 clocks and then low for D+1 clocks, where D = `gate_cfg[7:0]`. Its period is therefore 2(D+1) clocks.
- R5: `gate_cfg[8]` ANDs the carrier into the high-side outputs (even bits) and `gate_cfg[9]` ANDs it into the low-side outputs (odd bits). An output whose chop enable is low is not affected by the carrier.
- R6: A high on `sw_shut` or `ocp_flag` forces all outputs low in the same cycle. From the next clock edge on, `timer_rst` is high.
- R7: `trip_n` is active low and passes through two flip-flops. The outputs go low after the second rising edge following the pin falling, and not before.
- R8: The shutdown stays latched after every source has gone inactive. `shut_clr` releases it at the next edge only while no source is active; otherwise the clear request has no effect.
- R9: `shut_irq` pulses high for exactly one cycle, on the same edge at which the latch is set, and does so once per entry into shutdown.
- R10: After reset the latch is clear, `timer_rst` and `shut_irq` are low, the trip synchronizer holds the inactive level, and the outputs follow R1–R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 6 | Raw timer signals AH, AL, BH, BL, CH, CL (bit 0 up) |
| seg_cfg | input | 9 | [2:0] crossover for A, B, C; [8:3] output masks |
| gate_cfg | input | 10 | [7:0] carrier divisor D; [8] high-side chop; [9] low-side chop |
| trip_n | input | 1 | External trip, active low, asynchronous |
| ocp_flag | input | 1 | Over-current flag, active high |
| sw_shut | input | 1 | Software shutdown, active high |
| shut_clr | input | 1 | Request to clear the latched shutdown |
| pwm_out | output | 6 | Gate outputs, same bit order as `pwm_raw` |
| timer_rst | output | 1 | Timer reset, high while shutdown is latched |
| shut_irq | output | 1 | One-cycle shutdown interrupt request |

## Verification
The embedded assertions check the rules that hold on every cycle:
- zero outputs while the latch is set;
- the latch holding in the absence of a clear;
- the single-cycle width of the interrupt pulse;
- the carrier toggling only at the divisor limit;
- masked outputs staying low.

Some properties are only visible over sequences of stimulus, so the bench's scenarios show them:
- the exact carrier run lengths for several divisors;
- the full crossover/mask mapping over every raw pattern;
- the two-edge trip latency;
- the refusal of a clear while a source is still active.

// File: rtl/pwmo_pkg.sv
package pwmo_pkg;
  localparam int NUM_CH   = 3;
  localparam int NUM_OUT  = 2 * NUM_CH;
  localparam int SEG_W    = NUM_CH + NUM_OUT;
  localparam int DIV_W    = 8;
  localparam int GATE_W   = DIV_W + 2;

  typedef struct packed {
    logic trip;
    logic ocp;
    logic sw;
  } shut_src_t;
endpackage

// File: rtl/pwmo_sync.sv
module pwmo_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwmo_chop.sv
module pwmo_chop
  import pwmo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_lim,
  output logic             carrier
);
  logic [DIV_W-1:0] cnt_q;
  logic             car_q;
  logic             wrap;

  assign wrap = (cnt_q >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      car_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier = car_q;

  AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(car_q)) else $error("carrier moved before limit"); // R4
  AST_CARRIER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (car_q != $past(car_q))) else $error("carrier missed toggle"); // R4
endmodule

// File: rtl/pwmo_shutdown.sv
module pwmo_shutdown
  import pwmo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  shut_src_t src,
  input  logic      clr_req,
  output logic      latched,
  output logic      src_any,
  output logic      irq
);
  logic shut_q;
  logic irq_q;

  assign src_any = src.trip | src.ocp | src.sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= src_any & ~shut_q;
      if (src_any)      shut_q <= 1'b1;
      else if (clr_req) shut_q <= 1'b0;
    end
  end

  assign latched = shut_q;
  assign irq     = irq_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !clr_req) |=> shut_q) else $error("latch dropped"); // R8
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    src_any |=> shut_q) else $error("source did not latch"); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q) else $error("irq wider than one cycle"); // R9
endmodule

// File: rtl/pwm_out_ctrl.sv
module pwm_out_ctrl
  import pwmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_OUT-1:0] pwm_raw,
  input  logic [SEG_W-1:0]  seg_cfg,
  input  logic [GATE_W-1:0] gate_cfg,
  input  logic              trip_n,
  input  logic              ocp_flag,
  input  logic              sw_shut,
  input  logic              shut_clr,
  output logic [NUM_OUT-1:0] pwm_out,
  output logic              timer_rst,
  output logic              shut_irq
);
  logic              trip_n_s;
  logic              carrier;
  logic              latched;
  logic              src_any;
  logic              block;
  shut_src_t         src;
  logic [NUM_OUT-1:0] routed;

  pwmo_sync #(.STAGES(2), .RST_VAL(1'b1)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .din(trip_n), .dout(trip_n_s)
  );

  pwmo_chop u_chop (
    .clk(clk), .rst_n(rst_n), .div_lim(gate_cfg[DIV_W-1:0]), .carrier(carrier)
  );

  assign src.trip = ~trip_n_s;
  assign src.ocp  = ocp_flag;
  assign src.sw   = sw_shut;

  pwmo_shutdown u_shut (
    .clk(clk), .rst_n(rst_n), .src(src), .clr_req(shut_clr),
    .latched(latched), .src_any(src_any), .irq(shut_irq)
  );

  assign block     = latched | src_any;
  assign timer_rst = latched;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cross
    assign routed[2*c]   = seg_cfg[c] ? pwm_raw[2*c+1] : pwm_raw[2*c];
    assign routed[2*c+1] = seg_cfg[c] ? pwm_raw[2*c]   : pwm_raw[2*c+1];
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic chop_on;
    assign chop_on    = gate_cfg[DIV_W + (i % 2)];
    assign pwm_out[i] = routed[i] & ~seg_cfg[NUM_CH+i] & (~chop_on | carrier) & ~block;

    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      seg_cfg[NUM_CH+i] |-> !pwm_out[i]) else $error("masked output high"); // R3
  end

  AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst |-> (pwm_out == '0)) else $error("output during shutdown"); // R6
  AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shut_irq |-> (timer_rst && !$past(timer_rst))) else $error("irq not at entry"); // R9
endmodule

// File: tb/pwm_out_ctrl_tb_top.sv
module pwm_out_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pwm_raw = '0;
  logic [8:0] seg_cfg = '0;
  logic [9:0] gate_cfg = '0;
  logic       trip_n = 1'b1, ocp_flag = 1'b0, sw_shut = 1'b0, shut_clr = 1'b0;
  logic [5:0] pwm_out;
  logic       timer_rst, shut_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_out_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .seg_cfg(seg_cfg),
    .gate_cfg(gate_cfg), .trip_n(trip_n), .ocp_flag(ocp_flag),
    .sw_shut(sw_shut), .shut_clr(shut_clr), .pwm_out(pwm_out),
    .timer_rst(timer_rst), .shut_irq(shut_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model(input logic [5:0] raw, input logic [8:0] seg);
    logic [5:0] r;
    for (int c = 0; c < 3; c++) begin
      r[2*c]   = seg[c] ? raw[2*c+1] : raw[2*c];
      r[2*c+1] = seg[c] ? raw[2*c]   : raw[2*c+1];
    end
    return r & ~seg[8:3];
  endfunction

  task automatic step(); @(negedge clk); #1; endtask

  // Measure one complete high run and one low run of pwm_out[bit]
  task automatic runs(input int bitn, output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (pwm_out[bitn] !== 1'b0 && guard < 600) begin step(); guard++; end
    while (pwm_out[bitn] !== 1'b1 && guard < 600) begin step(); guard++; end
    while (pwm_out[bitn] === 1'b1 && guard < 1200) begin hi++; step(); guard++; end
    while (pwm_out[bitn] === 1'b0 && guard < 1800) begin lo++; step(); guard++; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    int divs[5] = '{0, 1, 2, 5, 13};
    step(); step();
    // R10 reset state
    chk("R10 timer_rst", timer_rst, 0);
    chk("R10 irq", shut_irq, 0);
    rst_n = 1'b1;
    pwm_raw = 6'b101101; step();
    chk("R10 outputs follow raw", pwm_out, 6'b101101);
    chk("R10 no latch", timer_rst, 0);

    // R1, R2, R3 exhaustive sweep
    for (int s = 0; s < 512; s++) begin
      for (int r = 0; r < 64; r++) begin
        seg_cfg = s[8:0]; pwm_raw = r[5:0];
        #1;
        if (s[2:0] == 0 && s[8:3] == 0) chk("R1 straight", pwm_out, r);
        else if (s[8:3] == 0)           chk("R2 crossover", pwm_out, model(r[5:0], s[8:0]));
        else                            chk("R3 masks", pwm_out, model(r[5:0], s[8:0]));
      end
    end
    seg_cfg = '0; pwm_raw = 6'h3F; step();

    // R4, R5 carrier length and side selection
    for (int k = 0; k < 5; k++) begin
      gate_cfg = {2'b01, divs[k][7:0]};
      repeat (40) step();
      runs(0, hi, lo);
      chk("R4 high run", hi, divs[k] + 1);
      chk("R4 low run", lo, divs[k] + 1);
      chk("R5 low side unchopped", pwm_out[1], 1);
      gate_cfg = {2'b10, divs[k][7:0]};
      repeat (40) step();
      runs(1, hi, lo);
      chk("R4 low side high run", hi, divs[k] + 1);
      chk("R5 high side unchopped", pwm_out[0], 1);
    end
    gate_cfg = '0; step();

    // R6 software shutdown, R9 irq
    chk("R6 pre", pwm_out, 6'h3F);
    sw_shut = 1'b1; #1;
    chk("R6 same-cycle block", pwm_out, 0);
    chk("R6 no timer_rst before edge", timer_rst, 0);
    step();
    chk("R6 timer_rst", timer_rst, 1);
    chk("R9 irq pulse", shut_irq, 1);
    sw_shut = 1'b0; step();
    chk("R9 irq single", shut_irq, 0);
    chk("R8 latch held", timer_rst, 1);
    chk("R8 outputs still low", pwm_out, 0);
    shut_clr = 1'b1; step(); shut_clr = 1'b0; #1;
    chk("R8 cleared", timer_rst, 0);
    chk("R8 outputs restored", pwm_out, 6'h3F);

    // R8 clear refused while over-current active
    ocp_flag = 1'b1; #1;
    chk("R6 ocp block", pwm_out, 0);
    step();
    chk("R9 irq on ocp", shut_irq, 1);
    shut_clr = 1'b1; step(); step();
    chk("R8 clear ignored", timer_rst, 1);
    chk("R9 no second irq", shut_irq, 0);
    ocp_flag = 1'b0; step(); shut_clr = 1'b0; #1;
    chk("R8 clear after source gone", timer_rst, 0);
    chk("R8 outputs back", pwm_out, 6'h3F);

    // R7 trip synchronizer latency
    trip_n = 1'b0; #1;
    chk("R7 no immediate effect", pwm_out, 6'h3F);
    step();
    chk("R7 one edge not enough", pwm_out, 6'h3F);
    step();
    chk("R7 blocked after two edges", pwm_out, 0);
    chk("R9 irq on trip", shut_irq, 0);
    step();
    chk("R9 irq one edge after trip seen", shut_irq, 1);
    trip_n = 1'b1; repeat (3) step();
    chk("R8 trip latched", timer_rst, 1);
    shut_clr = 1'b1; step(); shut_clr = 1'b0; #1;
    chk("R8 trip cleared", pwm_out, 6'h3F);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule